// File: doc/BRIEF.md
# Miss Entry Target Placement

This block is one outstanding-miss entry of a cache. A miss opens the entry with a first request. Later requests to the same line join the entry as targets. Each target is stored in one of two small in-order queues. The primary queue is served by the request already going downstream. The deferred queue waits for a second request that the cache issues after the first response. A request that arrives from a snoop is placed in the primary queue, but it takes no part in the queue's summary flags.

For each queue the block reports three summary flags, recomputed from the targets the queue currently holds. These are: a target wants write permission, an upgrade-class command is present, and the line should be kept on fill. When the entry issues downstream, the block records whether a writable line is expected. Snoop logic outside the block can mark the entry as due to be invalidated, due to be downgraded, or forwarded. From these marks the block decides where each new target goes. Once the line is known to be lost, it also rewrites upgrade-class commands into their fallback forms. The owner of the entry removes targets from the head of either queue as it serves them. An illegal operation raises a one-cycle error pulse and changes no state.

Top module: `miss_entry_targets`

## Requirements
- R1: After reset no entry is open and both queues are empty. Opening an entry (`open_valid`) stores the first target in the primary queue. Its source is 1 (prefetch) if the command is 7 (hardware prefetch) and 0 (CPU) otherwise. It clears the issued state. Opening while either queue holds targets is illegal.
- R2: Each queue flag is the OR over the non-snoop targets it holds. `*_wr` is the write-permission bit. `*_upg` is set by commands 2 (upgrade), 3 (SC-upgrade) and 5 (store-conditional). `*_keep` is the keep-on-fill bit. Command codes are: 0 read, 1 read-exclusive, 2 upgrade, 3 SC-upgrade, 4 SC-upgrade-fail, 5 store-conditional, 6 store-conditional-fail, 7 hardware prefetch.
- R3: A snoop target (`join_snoop`) always enters the primary queue with source 2 and leaves that queue's flags unchanged.
- R4: A non-snoop target is deferred in any of these cases: it is a maintenance request; the primary head is a maintenance request; the deferred queue is non-empty; or the entry has issued and either the invalidate mark is set or the target wants write permission while any of these holds: no writable line is expected, the downgrade mark is set, or the entry is forwarded. Otherwise the target joins the primary queue.
- R5: A target deferred while the entry has issued and the invalidate mark is set is stored rewritten: 2 becomes 1, 3 becomes 4, and 5 becomes 6. Other codes are stored unchanged.
- R6: A join is illegal and stores nothing in any of these cases: no entry is open, the entry is uncacheable, or a non-snoop command is 7. Issuing more than one of open, join, issue and release in one cycle is also illegal. `fault` pulses in the cycle after any illegal operation.
- R7: Issuing the entry (`issue_valid`) sets `issued` and clears both marks. It sets `expect_wr` to the primary write flag OR `issue_wr_resp`. Issuing an entry that is already issued is illegal.
- R8: Releasing the entry requires an empty primary queue and is illegal otherwise. A legal release closes the entry and clears `issued`.
- R9: Each queue holds up to DEPTH (8) targets and keeps arrival order. `join_ready` is low when the queue a join would enter is full, and a join offered then is not taken and raises no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| open_valid | input | 1 | Open the entry with a first request |
| open_cmd | input | 3 | Command of the first request |
| open_cmo | input | 1 | First request is a maintenance request |
| open_wr | input | 1 | First request wants write permission |
| open_keep | input | 1 | First request's keep-on-fill bit |
| open_unc | input | 1 | Entry is uncacheable |
| join_valid | input | 1 | Offer a later target |
| join_cmd | input | 3 | Command of the target |
| join_cmo | input | 1 | Target is a maintenance request |
| join_wr | input | 1 | Target wants write permission |
| join_keep | input | 1 | Target's keep-on-fill bit |
| join_snoop | input | 1 | Target comes from a snoop |
| join_ready | output | 1 | Queue chosen for the offered target has room |
| issue_valid | input | 1 | Downstream request issues |
| issue_wr_resp | input | 1 | Response is known to be writable |
| release_valid | input | 1 | Release the entry |
| mark_inv | input | 1 | Set the invalidate mark |
| mark_dgr | input | 1 | Set the downgrade mark |
| mark_fwd | input | 1 | Mark the entry as forwarded |
| pri_take | input | 1 | Remove the primary head |
| def_take | input | 1 | Remove the deferred head |
| open | output | 1 | Entry is open |
| issued | output | 1 | Downstream request has issued |
| expect_wr | output | 1 | Writable line expected |
| inv_mark | output | 1 | Invalidate mark |
| dgr_mark | output | 1 | Downgrade mark |
| pri_count | output | 4 | Targets in the primary queue |
| def_count | output | 4 | Targets in the deferred queue |
| pri_cmd | output | 3 | Primary head command |
| pri_src | output | 2 | Primary head source (0 CPU, 1 prefetch, 2 snoop) |
| def_cmd | output | 3 | Deferred head command |
| def_src | output | 2 | Deferred head source |
| pri_wr | output | 1 | Primary write-permission flag |
| pri_upg | output | 1 | Primary upgrade flag |
| pri_keep | output | 1 | Primary keep-on-fill flag |
| def_wr | output | 1 | Deferred write-permission flag |
| def_upg | output | 1 | Deferred upgrade flag |
| def_keep | output | 1 | Deferred keep-on-fill flag |
| fault | output | 1 | Illegal operation in the previous cycle |

## Verification
A wrong placement decision appears at the counts on the edge after the join, and at the head fields once the queue is drained. A missed rewrite appears at `def_upg` at once, and in the drained command value. Flag errors, such as a snoop target leaking into a flag or a stale write-permission bit, show at the flag outputs one cycle after the change. They also show through `expect_wr` on the next issue. A wrong legality check shows at `fault` and at counts that did or did not move, both one cycle after the operation.

// File: rtl/miss_entry_targets.sv
module miss_entry_targets #(
  parameter int DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       open_valid,
  input  logic [2:0] open_cmd,
  input  logic       open_cmo,
  input  logic       open_wr,
  input  logic       open_keep,
  input  logic       open_unc,
  input  logic       join_valid,
  input  logic [2:0] join_cmd,
  input  logic       join_cmo,
  input  logic       join_wr,
  input  logic       join_keep,
  input  logic       join_snoop,
  output logic       join_ready,
  input  logic       issue_valid,
  input  logic       issue_wr_resp,
  input  logic       release_valid,
  input  logic       mark_inv,
  input  logic       mark_dgr,
  input  logic       mark_fwd,
  input  logic       pri_take,
  input  logic       def_take,
  output logic       open,
  output logic       issued,
  output logic       expect_wr,
  output logic       inv_mark,
  output logic       dgr_mark,
  output logic [$clog2(DEPTH+1)-1:0] pri_count,
  output logic [$clog2(DEPTH+1)-1:0] def_count,
  output logic [2:0] pri_cmd,
  output logic [1:0] pri_src,
  output logic [2:0] def_cmd,
  output logic [1:0] def_src,
  output logic       pri_wr,
  output logic       pri_upg,
  output logic       pri_keep,
  output logic       def_wr,
  output logic       def_upg,
  output logic       def_keep,
  output logic       fault
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = 8;
  localparam logic [2:0] K_RDX = 3'd1, K_UPG = 3'd2, K_SCU = 3'd3, K_SCUF = 3'd4,
                         K_SC = 3'd5, K_SCF = 3'd6, K_PF = 3'd7;
  localparam logic [1:0] SRC_CPU = 2'd0, SRC_PF = 2'd1, SRC_SNP = 2'd2;

  logic [EW-1:0] slot [2][DEPTH];
  logic [AW-1:0] rd [2];
  logic [AW-1:0] wr [2];
  logic [CW-1:0] cnt [2];
  logic          v_q, unc_q, iss_q, xw_q, inv_q, dgr_q, fwd_q, flt_q;

  logic [1:0] f_wr, f_upg, f_keep, push, pop, full;
  logic       to_def, head_cmo, join_bad, join_ok, open_ok, issue_ok, rel_ok, many, bad_any;
  logic [2:0] store_cmd;
  logic [EW-1:0] push_ent;

  always_comb begin
    for (int l = 0; l < 2; l++) begin
      f_wr[l] = 1'b0; f_upg[l] = 1'b0; f_keep[l] = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        int d;
        d = (i >= int'(rd[l])) ? i - int'(rd[l]) : i + DEPTH - int'(rd[l]);
        if (d < int'(cnt[l]) && slot[l][i][4:3] != SRC_SNP) begin
          f_wr[l]   = f_wr[l] | slot[l][i][6];
          f_keep[l] = f_keep[l] | slot[l][i][5];
          f_upg[l]  = f_upg[l] | (slot[l][i][2:0] == K_UPG) | (slot[l][i][2:0] == K_SCU) |
                      (slot[l][i][2:0] == K_SC);
        end
      end
      full[l] = (cnt[l] == CW'(DEPTH));
    end
  end

  assign head_cmo  = (cnt[0] != '0) && slot[0][rd[0]][7];
  assign to_def    = !join_snoop && (join_cmo || head_cmo || cnt[1] != '0 ||
                     (iss_q && (inv_q || (join_wr && (!xw_q || dgr_q || fwd_q)))));
  assign join_ready = !full[to_def];
  assign many      = (int'(open_valid) + int'(join_valid) + int'(issue_valid) + int'(release_valid)) > 1;
  assign join_bad  = join_valid && (!v_q || unc_q || (!join_snoop && join_cmd == K_PF));
  assign join_ok   = join_valid && join_ready && !join_bad && !many;
  assign open_ok   = open_valid && cnt[0] == '0 && cnt[1] == '0 && !many;
  assign issue_ok  = issue_valid && v_q && !iss_q && !many;
  assign rel_ok    = release_valid && cnt[0] == '0 && !many;
  assign bad_any   = many || join_bad || (open_valid && !open_ok) ||
                     (issue_valid && !issue_ok) || (release_valid && !rel_ok);

  always_comb begin
    store_cmd = join_cmd;
    if (to_def && iss_q && inv_q) begin
      case (join_cmd)
        K_UPG:   store_cmd = K_RDX;
        K_SCU:   store_cmd = K_SCUF;
        K_SC:    store_cmd = K_SCF;
        default: store_cmd = join_cmd;
      endcase
    end
  end

  always_comb begin
    push = 2'b00;
    push_ent = '0;
    if (open_ok) begin
      push[0]  = 1'b1;
      push_ent = {open_cmo, open_wr, open_keep, (open_cmd == K_PF) ? SRC_PF : SRC_CPU, open_cmd};
    end else if (join_ok) begin
      push[to_def] = 1'b1;
      push_ent = {join_cmo, join_wr, join_keep, join_snoop ? SRC_SNP : SRC_CPU, store_cmd};
    end
  end

  assign pop[0] = pri_take && cnt[0] != '0;
  assign pop[1] = def_take && cnt[1] != '0;

  for (genvar l = 0; l < 2; l++) begin : g_q
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rd[l] <= '0; wr[l] <= '0; cnt[l] <= '0;
      end else begin
        if (push[l]) wr[l] <= (wr[l] == AW'(DEPTH - 1)) ? '0 : wr[l] + 1'b1;
        if (pop[l])  rd[l] <= (rd[l] == AW'(DEPTH - 1)) ? '0 : rd[l] + 1'b1;
        cnt[l] <= cnt[l] + CW'(push[l]) - CW'(pop[l]);
      end
    end
    always_ff @(posedge clk) if (push[l]) slot[l][wr[l]] <= push_ent;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= 1'b0; unc_q <= 1'b0; iss_q <= 1'b0; xw_q <= 1'b0;
      inv_q <= 1'b0; dgr_q <= 1'b0; fwd_q <= 1'b0; flt_q <= 1'b0;
    end else begin
      flt_q <= bad_any;
      if (open_ok) begin
        v_q <= 1'b1; unc_q <= open_unc; iss_q <= 1'b0; xw_q <= 1'b0;
        inv_q <= 1'b0; dgr_q <= 1'b0; fwd_q <= 1'b0;
      end
      if (issue_ok) begin
        iss_q <= 1'b1; xw_q <= f_wr[0] | issue_wr_resp;
        inv_q <= 1'b0; dgr_q <= 1'b0;
      end
      if (rel_ok) begin
        v_q <= 1'b0; iss_q <= 1'b0; xw_q <= 1'b0;
        inv_q <= 1'b0; dgr_q <= 1'b0; fwd_q <= 1'b0;
      end
      if (v_q && !rel_ok) begin
        if (mark_inv) inv_q <= 1'b1;
        if (mark_dgr) dgr_q <= 1'b1;
        if (mark_fwd) fwd_q <= 1'b1;
      end
    end
  end

  assign open = v_q;   assign issued = iss_q;   assign expect_wr = xw_q;
  assign inv_mark = inv_q;   assign dgr_mark = dgr_q;   assign fault = flt_q;
  assign pri_count = cnt[0];  assign def_count = cnt[1];
  assign pri_cmd = slot[0][rd[0]][2:0];  assign pri_src = slot[0][rd[0]][4:3];
  assign def_cmd = slot[1][rd[1]][2:0];  assign def_src = slot[1][rd[1]][4:3];
  assign pri_wr = f_wr[0]; assign pri_upg = f_upg[0]; assign pri_keep = f_keep[0];
  assign def_wr = f_wr[1]; assign def_upg = f_upg[1]; assign def_keep = f_keep[1];

  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt[0] <= CW'(DEPTH) && cnt[1] <= CW'(DEPTH));
  p_issue_r7: assert property (@(posedge clk) disable iff (!rst_n)
    issue_ok && !mark_inv && !mark_dgr |=> iss_q && !inv_q && !dgr_q);
  p_bad_join_r6: assert property (@(posedge clk) disable iff (!rst_n)
    join_bad && !pri_take && !def_take |=> flt_q && $stable(cnt[0]) && $stable(cnt[1]));
  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rel_ok |=> !iss_q && !v_q);
  p_defer_chain_r4: assert property (@(posedge clk) disable iff (!rst_n)
    join_ok && !join_snoop && cnt[1] != '0 && !def_take |=> cnt[1] == $past(cnt[1]) + 1'b1);
  p_snoop_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
    join_ok && join_snoop && !pri_take |=> f_wr[0] == $past(f_wr[0]) && f_upg[0] == $past(f_upg[0]));
endmodule

// File: tb/sim_miss_entry_targets.sv
module sim_miss_entry_targets;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic open_valid = 0, open_cmo = 0, open_wr = 0, open_keep = 0, open_unc = 0;
  logic [2:0] open_cmd = 0, join_cmd = 0;
  logic join_valid = 0, join_cmo = 0, join_wr = 0, join_keep = 0, join_snoop = 0;
  logic issue_valid = 0, issue_wr_resp = 0, release_valid = 0;
  logic mark_inv = 0, mark_dgr = 0, mark_fwd = 0, pri_take = 0, def_take = 0;
  logic join_ready, open, issued, expect_wr, inv_mark, dgr_mark, fault;
  logic [3:0] pri_count, def_count;
  logic [2:0] pri_cmd, def_cmd;
  logic [1:0] pri_src, def_src;
  logic pri_wr, pri_upg, pri_keep, def_wr, def_upg, def_keep;

  miss_entry_targets u0 (.*);

  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic [4:0] exp_pri[$], exp_def[$];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_open(logic [2:0] c, logic cmo, logic w, logic k, logic unc, bit ok);
    open_valid = 1; open_cmd = c; open_cmo = cmo; open_wr = w; open_keep = k; open_unc = unc;
    @(negedge clk); open_valid = 0;
    if (ok) exp_pri.push_back({(c == 3'd7) ? 2'd1 : 2'd0, c});
  endtask

  task automatic do_join(logic [2:0] c, logic cmo, logic w, logic k, logic snp, int lst, logic [2:0] ec);
    join_valid = 1; join_cmd = c; join_cmo = cmo; join_wr = w; join_keep = k; join_snoop = snp;
    @(negedge clk); join_valid = 0; join_snoop = 0; join_cmo = 0;
    if (lst == 0) exp_pri.push_back({snp ? 2'd2 : 2'd0, ec});
    if (lst == 1) exp_def.push_back({2'd0, ec});
  endtask

  task automatic do_issue(logic m);
    issue_valid = 1; issue_wr_resp = m; @(negedge clk); issue_valid = 0; issue_wr_resp = 0;
  endtask

  task automatic do_release();
    release_valid = 1; @(negedge clk); release_valid = 0;
  endtask

  task automatic pulse_mark(logic i, logic d, logic f);
    mark_inv = i; mark_dgr = d; mark_fwd = f; @(negedge clk);
    mark_inv = 0; mark_dgr = 0; mark_fwd = 0;
  endtask

  // monitor side of the scoreboard: pop expected items and compare the queue heads
  task automatic drain(string req);
    while (exp_pri.size() > 0) begin
      logic [4:0] e;
      e = exp_pri.pop_front();
      chk({req, " primary order"}, {pri_src, pri_cmd}, e);
      pri_take = 1; @(negedge clk); pri_take = 0;
    end
    chk({req, " primary empty"}, pri_count, 0);
    while (exp_def.size() > 0) begin
      logic [4:0] e;
      e = exp_def.pop_front();
      chk({req, " deferred order"}, {def_src, def_cmd}, e);
      def_take = 1; @(negedge clk); def_take = 0;
    end
    chk({req, " deferred empty"}, def_count, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);
    // R1 reset state
    chk("R1 reset open", open, 0);
    chk("R1 reset counts", {pri_count, def_count}, 0);
    chk("R1 reset fault", fault, 0);

    // scenario A
    do_open(3'd7, 0, 0, 1, 0, 1);
    chk("R1 prefetch source", pri_src, 1);
    chk("R1 not issued", {issued, expect_wr}, 0);
    chk("R2 keep flag", pri_keep, 1);
    do_join(3'd1, 0, 1, 0, 1, 0, 3'd1);
    chk("R3 snoop leaves wr flag", pri_wr, 0);
    chk("R3 snoop to primary", pri_count, 2);
    do_join(3'd0, 0, 0, 0, 0, 0, 3'd0);
    do_join(3'd2, 0, 1, 0, 0, 0, 3'd2);
    chk("R2 wr and upg flags", {pri_wr, pri_upg}, 2'b11);
    do_join(3'd7, 0, 0, 0, 0, -1, 0);
    chk("R6 prefetch join fault", fault, 1);
    chk("R6 prefetch join not stored", pri_count, 4);
    do_issue(0);
    chk("R7 issued and expect_wr", {issued, expect_wr}, 2'b11);
    do_issue(0);
    chk("R7 double issue fault", fault, 1);
    do_join(3'd1, 0, 1, 0, 0, 0, 3'd1);
    chk("R4 writable expected stays primary", {pri_count, def_count}, {4'd5, 4'd0});
    pulse_mark(0, 1, 0);
    do_join(3'd1, 0, 1, 0, 0, 1, 3'd1);
    chk("R4 downgrade defers", def_count, 1);
    chk("R2 deferred wr flag", def_wr, 1);
    do_join(3'd0, 0, 0, 0, 0, 1, 3'd0);
    chk("R4 deferred nonempty defers", def_count, 2);
    do_release();
    chk("R8 release with primary fault", {fault, open}, 2'b11);
    drain("R9 scenario A");
    do_release();
    chk("R8 release closes", {open, issued, fault}, 3'b000);
    do_join(3'd0, 0, 0, 0, 0, -1, 0);
    chk("R6 join without entry", {fault, pri_count}, {1'b1, 4'd0});

    // scenario B: rewrites
    do_open(3'd0, 0, 0, 0, 0, 1);
    chk("R1 cpu source", pri_src, 0);
    do_join(3'd0, 1, 0, 0, 0, 1, 3'd0);
    chk("R4 maintenance join defers", def_count, 1);
    do_issue(1);
    chk("R7 expect_wr from response", expect_wr, 1);
    pulse_mark(1, 0, 0);
    chk("R7 inv mark set", inv_mark, 1);
    do_join(3'd2, 0, 0, 0, 0, 1, 3'd1);
    do_join(3'd5, 0, 0, 0, 0, 1, 3'd6);
    do_join(3'd3, 0, 0, 0, 0, 1, 3'd4);
    chk("R5 rewritten no upg flag", def_upg, 0);
    drain("R5 scenario B");
    do_release();

    // scenario C: issue clears marks, forward defers
    do_open(3'd1, 0, 1, 0, 0, 1);
    pulse_mark(1, 1, 0);
    do_issue(0);
    chk("R7 marks cleared", {inv_mark, dgr_mark, expect_wr}, 3'b001);
    pulse_mark(0, 0, 1);
    do_join(3'd0, 0, 0, 0, 0, 0, 3'd0);
    do_join(3'd1, 0, 1, 0, 0, 1, 3'd1);
    chk("R4 forward defers writable", {pri_count, def_count}, {4'd2, 4'd1});
    drain("R4 scenario C");
    do_release();

    // scenario D: maintenance head
    do_open(3'd0, 1, 0, 0, 0, 1);
    do_join(3'd0, 0, 0, 0, 0, 1, 3'd0);
    chk("R4 maintenance head defers", def_count, 1);
    do_open(3'd0, 0, 0, 0, 0, 0);
    chk("R1 open while occupied fault", fault, 1);
    drain("R4 scenario D");
    do_release();

    // scenario E: uncacheable
    do_open(3'd0, 0, 0, 0, 1, 1);
    do_join(3'd0, 0, 0, 0, 0, -1, 0);
    chk("R6 uncacheable join fault", {fault, pri_count}, {1'b1, 4'd1});
    drain("R6 scenario E");
    do_release();

    // scenario F: full primary queue
    do_open(3'd0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 7; i++) do_join(3'(i % 2), 0, 0, 0, 0, 0, 3'(i % 2));
    chk("R9 full count", pri_count, 8);
    join_cmd = 3'd0; join_wr = 0; #1;
    chk("R9 ready low when full", join_ready, 0);
    do_join(3'd0, 0, 0, 0, 0, -1, 0);
    chk("R9 full join not taken", {pri_count, fault}, {4'd8, 1'b0});
    drain("R9 scenario F");
    do_release();
    chk("R9 ready after drain", join_ready, 1);

    finish_run();
  end
endmodule